// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt flags from two sources and issues interrupt requests to a CPU pipeline. The first source is an external pin, which the block watches for a low level or for an edge. The second is a timer overflow, which arrives as a one-cycle set pulse. Each source has a flag bit and a mask bit in byte-wide registers. A source counts as pending only when both of its bits are set.

Among the pending sources the block picks one by fixed priority. The external pin always beats the timer. No source can win while the global interrupt enable is low or while the pipeline-busy inhibit is high. When a source wins, the block raises its request output for one clock and drives the source's vector on the vector output. In the same cycle it clears the flag of the winning source. A small register port gives software read and write access to the sense-control, mask and flag bytes.

Top module: `irq_arbiter`

## Requirements
- R1: Asynchronous reset (`rst_n` low) and synchronous reset (`sync_clr` high at a clock edge) both clear the control, mask and flag registers, the registered pin history, the request and the vector. Synchronous reset overrides every other update in that cycle.
- R2: The register port selects a register with `reg_sel_i`: 0 is sense control, 1 is mask, 2 is flags. A write replaces the whole byte at the clock edge. `reg_rdata_o` shows the selected register combinationally, and select 3 reads as 0.
- R3: When control bits [1:0] are 00, the external flag (flag bit 6) is set at every clock edge at which `ext_pin_i` is low.
- R4: When control bits [1:0] are 10, the external flag is set on a falling edge. When they are 11, it is set on a rising edge. An edge is found by comparing the pin with its value at the previous clock edge.
- R5: Control code 01 is reserved. Under it, the pin never sets the external flag.
- R6: A high `tmr_ovf_i` at a clock edge sets the timer flag (flag bit 1).
- R7: A source is pending only when both its flag bit and its mask bit are 1. The external source uses bit 6 and the timer source uses bit 1. A set flag with a clear mask bit produces no request and stays set.
- R8: While `irq_en_i` is low, no request is issued.
- R9: While `busy_i` is high, no request is issued.
- R10: When both sources are pending, only the external source is acknowledged. The timer flag stays set and wins at a later edge.
- R11: A request is issued at the clock edge after a source becomes pending and unblocked. `irq_req_o` is then 1 for that cycle, and `irq_vec_o` carries `EXT_VEC` (default 1) or `TOV_VEC` (default 9). In every other cycle both outputs are 0.
- R12: The winning source's flag is cleared at the same edge that raises its request.
- R13: A hardware flag set (pin sense or timer pulse) wins over a software write to the flag register and over the acknowledge clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous reset, active high |
| busy_i | input | 1 | Pipeline-busy inhibit |
| irq_en_i | input | 1 | Global interrupt enable (status bit) |
| ext_pin_i | input | 1 | External interrupt pin |
| tmr_ovf_i | input | 1 | Timer overflow set pulse |
| reg_sel_i | input | 2 | Register select: 0 control, 1 mask, 2 flags |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Selected register contents |
| irq_req_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | VEC_W | Vector of the winning source, 0 when idle |

## Verification
A flag set by the pin or by the timer pulse appears at the first clock edge after the stimulus. The request and vector appear one edge later, and that same edge clears the winning flag. A register write shows on the read port once its edge has passed, because the read path has no register. The bench drives and samples only on falling clock edges. It waits exactly two rising edges after applying a stimulus before it compares the request, the vector and the flag byte. For the loser of a priority contest it checks one more edge later.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_MASK = 2'd1,
      SEL_FLAG = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

endpackage

// File: rtl/irq_sense.sv
module irq_sense
   import irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_clr,
   input  logic       pin_i,
   input  logic [1:0] mode_i,
   output logic       set_o
);

   logic pin_q;

   // pin history register, cleared by either reset (R1)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pin_q <= 1'b0;
      else if (sync_clr) pin_q <= 1'b0;
      else               pin_q <= pin_i;
   end

   always_comb begin
      unique case (sense_e'(mode_i))
         SENSE_LOW:  set_o = ~pin_i;
         SENSE_FALL: set_o = pin_q & ~pin_i;
         SENSE_RISE: set_o = ~pin_q & pin_i;
         default:    set_o = 1'b0;
      endcase
   end

   // R5: the reserved code never raises a set, whatever the pin does
   assert_rsvd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SENSE_RSVD) |-> !set_o);

   // R4: a rising-edge set needs the pin low one edge earlier
   assert_rise_hist_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SENSE_RISE && set_o && !$past(sync_clr)) |-> !$past(pin_i));

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int NSRC = 2
) (
   input  logic [NSRC-1:0] req_i,
   output logic [NSRC-1:0] grant_o
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("irq_prio: NSRC must be at least 1");
   end

   logic [NSRC-1:0] taken;

   assign taken[0] = 1'b0;
   for (genvar i = 0; i < NSRC; i++) begin : g_lane
      if (i > 0) begin : g_chain
         assign taken[i] = taken[i-1] | req_i[i-1];
      end
      assign grant_o[i] = req_i[i] & ~taken[i];
   end

   // R10: at most one grant, and a grant only where a request stands
   always_comb begin
      assert_one_grant_R10: assert ($onehot0(grant_o));
      assert_grant_has_req_R10: assert ((grant_o & ~req_i) == '0);
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int VEC_W   = 22,
   parameter int EXT_VEC = 1,
   parameter int TOV_VEC = 9,
   parameter int EXT_BIT = 6,
   parameter int TOV_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_clr,
   input  logic              busy_i,
   input  logic              irq_en_i,
   input  logic              ext_pin_i,
   input  logic              tmr_ovf_i,
   input  logic [1:0]        reg_sel_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_req_o,
   output logic [VEC_W-1:0]  irq_vec_o
);

   localparam int NSRC    = 2;
   localparam int SRC_EXT = 0;   // index 0 has the highest priority
   localparam int SRC_TOV = 1;
   localparam logic [VEC_W-1:0] VEC_TAB [NSRC] = '{VEC_W'(EXT_VEC), VEC_W'(TOV_VEC)};

   if (DATA_W < 8) begin : g_bad_width
      $error("irq_arbiter: DATA_W must be at least 8");
   end
   if (EXT_BIT >= DATA_W || TOV_BIT >= DATA_W || EXT_BIT == TOV_BIT) begin : g_bad_bits
      $error("irq_arbiter: flag bit positions invalid");
   end
   if (EXT_VEC == 0 || TOV_VEC == 0 || EXT_VEC == TOV_VEC) begin : g_bad_vec
      $error("irq_arbiter: vectors must be distinct and nonzero");
   end

   logic [DATA_W-1:0] ctrl_q, mask_q, flag_q, flag_d;
   logic [NSRC-1:0]   pend, grant;
   logic [VEC_W-1:0]  vec_d;
   logic              ext_set, gate;

   irq_sense u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (sync_clr),
      .pin_i    (ext_pin_i),
      .mode_i   (ctrl_q[1:0]),
      .set_o    (ext_set)
   );

   assign pend[SRC_EXT] = flag_q[EXT_BIT] & mask_q[EXT_BIT];
   assign pend[SRC_TOV] = flag_q[TOV_BIT] & mask_q[TOV_BIT];
   assign gate          = irq_en_i & ~busy_i;

   irq_prio #(.NSRC(NSRC)) u_prio (
      .req_i   (pend & {NSRC{gate}}),
      .grant_o (grant)
   );

   // flag update order: software write, acknowledge clear, hardware set last
   always_comb begin
      flag_d = flag_q;
      if (reg_wr_i && reg_sel_e'(reg_sel_i) == SEL_FLAG) flag_d = reg_wdata_i;
      if (grant[SRC_EXT]) flag_d[EXT_BIT] = 1'b0;
      if (grant[SRC_TOV]) flag_d[TOV_BIT] = 1'b0;
      if (ext_set)        flag_d[EXT_BIT] = 1'b1;
      if (tmr_ovf_i)      flag_d[TOV_BIT] = 1'b1;
   end

   always_comb begin
      vec_d = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) vec_d = vec_d | VEC_TAB[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         mask_q    <= '0;
         flag_q    <= '0;
         irq_req_o <= 1'b0;
         irq_vec_o <= '0;
      end else if (sync_clr) begin
         ctrl_q    <= '0;
         mask_q    <= '0;
         flag_q    <= '0;
         irq_req_o <= 1'b0;
         irq_vec_o <= '0;
      end else begin
         if (reg_wr_i && reg_sel_e'(reg_sel_i) == SEL_CTRL) ctrl_q <= reg_wdata_i;
         if (reg_wr_i && reg_sel_e'(reg_sel_i) == SEL_MASK) mask_q <= reg_wdata_i;
         flag_q    <= flag_d;
         irq_req_o <= |grant;
         irq_vec_o <= vec_d;
      end
   end

   always_comb begin
      unique case (reg_sel_e'(reg_sel_i))
         SEL_CTRL: reg_rdata_o = ctrl_q;
         SEL_MASK: reg_rdata_o = mask_q;
         SEL_FLAG: reg_rdata_o = flag_q;
         default:  reg_rdata_o = '0;
      endcase
   end

   // R11: a request always carries one of the two vectors; idle cycles carry 0
   assert_vec_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (irq_vec_o == VEC_W'(EXT_VEC) || irq_vec_o == VEC_W'(TOV_VEC)));
   assert_vec_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req_o |-> (irq_vec_o == '0));
   // R9 / R8: inhibit and global enable block the next request
   assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> !irq_req_o);
   assert_en_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |=> !irq_req_o);
   // R10 / R11: a winning external source is the one reported next cycle
   assert_ext_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[SRC_EXT] && !sync_clr) |=> (irq_req_o && irq_vec_o == VEC_W'(EXT_VEC)));
   // R12: the acknowledged timer flag is gone unless a new pulse arrived
   assert_ack_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[SRC_TOV] && !tmr_ovf_i) |=> !flag_q[TOV_BIT]);
   // R1: synchronous reset leaves every register cleared
   assert_sync_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr |=> (ctrl_q == '0 && mask_q == '0 && flag_q == '0 && !irq_req_o));

endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;

   localparam int DW = 8;
   localparam int VW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_clr = 1'b0;
   logic          busy = 1'b0;
   logic          en = 1'b0;
   logic          pin = 1'b1;
   logic          tov = 1'b0;
   logic [1:0]    sel = 2'd0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          req;
   logic [VW-1:0] vec;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   irq_arbiter i_irq_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_clr    (sync_clr),
      .busy_i      (busy),
      .irq_en_i    (en),
      .ext_pin_i   (pin),
      .tmr_ovf_i   (tov),
      .reg_sel_i   (sel),
      .reg_wr_i    (wr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_req_o   (req),
      .irq_vec_o   (vec)
   );

   typedef struct packed {
      logic [1:0] mode;
      logic [7:0] mask;
      logic       en;
      logic       busy;
      logic       p0;     // pin during setup
      logic       p1;     // pin from stimulus on
      logic       tov;
      logic       req;    // expected request after second edge
      logic [7:0] vec;
      logic [7:0] flg;    // expected flag byte after second edge
   } row_t;

   localparam row_t TBL [0:13] = '{
      '{2'b00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h40}, // R3 level low, re-set
      '{2'b00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00}, // R3 pin high
      '{2'b10, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h00}, // R4 falling, R12 clear
      '{2'b10, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00}, // R4 wrong edge
      '{2'b11, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1, 8'h00}, // R4 rising
      '{2'b11, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'h00}, // R4 wrong edge
      '{2'b01, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'h00}, // R5 low level
      '{2'b01, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'h00}, // R5 falling
      '{2'b10, 8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd9, 8'h00}, // R6 timer, R11 vector
      '{2'b11, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'h42}, // R7 masked
      '{2'b11, 8'h42, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'h42}, // R8 disabled
      '{2'b11, 8'h42, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'h42}, // R9 busy
      '{2'b11, 8'h42, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1, 8'h02}, // R10 ext first
      '{2'b11, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9, 8'h40}  // R7 ext masked, timer wins
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic run_row(input row_t r);
      @(negedge clk);
      sync_clr = 1'b1; en = 1'b0; busy = 1'b0; pin = r.p0; tov = 1'b0; wr = 1'b0;
      @(negedge clk);
      sync_clr = 1'b0; wr = 1'b1; sel = 2'd0; wdata = {6'd0, r.mode};
      @(negedge clk);
      sel = 2'd1; wdata = r.mask;
      @(negedge clk);
      sel = 2'd2; wdata = 8'h00;
      @(negedge clk);
      wr = 1'b0; pin = r.p1; tov = r.tov; en = r.en; busy = r.busy;
      @(negedge clk);
      tov = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sel = 2'd0; #1 chk("R1 ctrl after reset", int'(rdata), 0);
      sel = 2'd1; #1 chk("R1 mask after reset", int'(rdata), 0);
      sel = 2'd2; #1 chk("R1 flags after reset", int'(rdata), 0);
      chk("R1 req after reset", int'(req), 0);
      chk("R11 vec idle after reset", int'(vec), 0);

      // R2: register port readback and whole-byte replace
      pin = 1'b1;
      reg_write(2'd1, 8'h5A);
      reg_write(2'd2, 8'hA5);
      sel = 2'd1; #1 chk("R2 mask readback", int'(rdata), 'h5A);
      sel = 2'd2; #1 chk("R2 flag byte replaced", int'(rdata), 'hA5);
      sel = 2'd3; #1 chk("R2 select 3 reads zero", int'(rdata), 0);
      reg_write(2'd0, 8'h03);
      sel = 2'd0; #1 chk("R2 ctrl readback", int'(rdata), 'h03);

      // table walk
      for (int i = 0; i < 14; i++) begin
         run_row(TBL[i]);
         sel = 2'd2;
         #1;
         chk($sformatf("table row %0d request", i), int'(req), int'(TBL[i].req));
         chk($sformatf("table row %0d vector", i), int'(vec), int'(TBL[i].vec));
         chk($sformatf("table row %0d flags", i), int'(rdata), int'(TBL[i].flg));
      end

      // R10: the losing timer flag is served one edge later, then R11 idle
      run_row(TBL[12]);
      @(negedge clk);
      chk("R10 timer served later req", int'(req), 1);
      chk("R10 timer served later vec", int'(vec), 9);
      @(negedge clk);
      chk("R11 request lasts one cycle", int'(req), 0);
      chk("R11 vector back to zero", int'(vec), 0);
      sel = 2'd2; #1 chk("R12 both flags cleared", int'(rdata), 0);

      // R13: hardware set beats a software flag write in the same cycle
      @(negedge clk);
      en = 1'b0; pin = 1'b0;
      reg_write(2'd0, 8'h03);
      @(negedge clk);
      wr = 1'b1; sel = 2'd2; wdata = 8'h00; pin = 1'b1; tov = 1'b1;
      @(negedge clk);
      wr = 1'b0; tov = 1'b0;
      #1 chk("R13 hw set over sw write", int'(rdata), 'h42);

      // R1: synchronous reset clears everything
      reg_write(2'd1, 8'hFF);
      @(negedge clk);
      sync_clr = 1'b1;
      @(negedge clk);
      sync_clr = 1'b0;
      sel = 2'd0; #1 chk("R1 sync ctrl", int'(rdata), 0);
      sel = 2'd1; #1 chk("R1 sync mask", int'(rdata), 0);
      sel = 2'd2; #1 chk("R1 sync flags", int'(rdata), 0);

      // R1: asynchronous reset mid-run
      reg_write(2'd1, 8'h42);
      #2 rst_n = 1'b0;
      #1 sel = 2'd1;
      #1 chk("R1 async mask", int'(rdata), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule